// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block turns single read and write commands from a clocked system into correctly timed strobe sequences for a 2048 x 8 asynchronous static RAM. The strobes are active-low chip select, write strobe and output enable. Each command arrives on a valid/ready port. The sequencer drives the address and the strobes for a fixed number of clock cycles. Each count is derived at elaboration from the clock period and the memory's nanosecond limits, rounding up. The counts cover access time, output-enable access, write pulse width, data setup before the write ends, output turn-off after the write strobe falls, data hold, write recovery and minimum cycle time.

The bidirectional memory data bus is split into an output value, an output enable and an input value, so that the pad can sit outside the block. A write holds the memory's output enable high for the whole cycle. The sequencer starts driving the bus only after the memory's worst-case turn-off time has passed. A read ends on the clock edge at which the access time has been met. The byte is captured on that edge and returned with a single-cycle response pulse.

Back-pressure rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the memory cycle and its recovery time are complete. The command fields are sampled only on the transfer edge and may change freely afterwards. The response side has no ready signal: `rsp_valid` is high for exactly one cycle, and the consumer must take the data in that cycle.

Top module: `sram_seq`

## Requirements
- R1: During and after reset, with no command, the chip select, write strobe and output enable are high, `mem_dq_oe` is low, `cmd_ready` is high and `rsp_valid` is low.
- R2: A command transfers only when `cmd_valid` and `cmd_ready` are both high at a rising edge. `cmd_ready` is low in the cycle after the transfer. Changing `cmd_addr` or `cmd_wdata` after the transfer does not affect the cycle in progress.
- R3: A read (`cmd_write` = 0) lowers chip select and output enable, with the write strobe high and `mem_addr` = `cmd_addr`, on the transfer edge. It keeps them low for RD = max(ceil(100 ns/T), ceil(50 ns/T), ceil(100 ns/T)-1) cycles, which is 13 at T = 8 ns.
- R4: `rsp_valid` is high for exactly one cycle, starting with the edge that releases the read strobes. `rsp_data` equals the memory data present just before that edge. `cmd_ready` rises in the same cycle.
- R5: A write (`cmd_write` = 1) lowers chip select and the write strobe together on the transfer edge. It raises them together WL = max(ceil(75 ns/T), ceil(35 ns/T)+ceil(40 ns/T)) cycles later, which is 10 at 8 ns. Output enable stays high throughout.
- R6: `mem_dq_oe` rises OD = ceil(35 ns/T) cycles after the write strobes fall, which is 5 at 8 ns. `mem_dq_out` then carries the command's data, so data is set up for WL-OD (at least ceil(40 ns/T)) cycles before the write ends.
- R7: After the write strobes rise, data stays driven for RC = max(ceil(10 ns/T), ceil(10 ns/T), ceil(100 ns/T)-WL, 1) cycles, which is 3 at 8 ns. `mem_dq_oe` then falls and `cmd_ready` rises on the same edge.
- R8: `mem_addr` does not change while chip select is low.
- R9: `mem_dq_oe` is never high while output enable is low.
- R10: The next command can transfer on the first edge after `cmd_ready` returns. Successive chip-select falling edges are at least ceil(100 ns/T) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted this edge if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 11 | Word address |
| cmd_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 8 | Captured read byte |
| mem_addr | output | 11 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Byte to drive on the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus pad |
| mem_dq_in | input | 8 | Byte seen on the data bus |

## Verification
A wrong phase count shows up directly at the memory pins. It appears as a strobe-low window one or more cycles off the derived length, or as a response or `cmd_ready` return at the wrong cycle after the transfer. All of these are visible within the same command. A capture on an early edge shows up as a wrong returned byte, because the bench's memory model presents valid data only once the access time has been met. A wrong write address or data latch is not visible until the location is read back. A full write-then-read sweep of every address therefore exposes it within one pass.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WDRV,
    ST_WREC
  } seq_state_t;

  // whole clock cycles needed to cover t_ps, rounded up
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] init,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= init;
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CW      = 4,
  parameter int RD_CYC  = 13,
  parameter int ODW_CYC = 5,
  parameter int DRV_CYC = 5,
  parameter int REC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          tmr_done,
  output logic          cmd_ready,
  output logic          accept,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_init,
  output logic          rd_capture,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          dq_drive
);

  seq_state_t state, nxt;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    nxt        = state;
    tmr_init   = '0;
    rd_capture = 1'b0;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        nxt      = cmd_write ? ST_WSET : ST_READ;
        tmr_init = cmd_write ? CW'(ODW_CYC - 1) : CW'(RD_CYC - 1);
      end
      ST_READ: if (tmr_done) begin
        nxt        = ST_IDLE;
        rd_capture = 1'b1;
      end
      ST_WSET: if (tmr_done) begin
        nxt      = ST_WDRV;
        tmr_init = CW'(DRV_CYC - 1);
      end
      ST_WDRV: if (tmr_done) begin
        nxt      = ST_WREC;
        tmr_init = CW'(REC_CYC - 1);
      end
      ST_WREC: if (tmr_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign tmr_load = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      dq_drive <= 1'b0;
    end else begin
      state    <= nxt;
      mem_ce_n <= !(nxt inside {ST_READ, ST_WSET, ST_WDRV});
      mem_we_n <= !(nxt inside {ST_WSET, ST_WDRV});
      mem_oe_n <= (nxt != ST_READ);
      dq_drive <= (nxt inside {ST_WDRV, ST_WREC});
    end
  end

  // R9: never drive the bus while the memory may drive it
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> mem_oe_n);
  // R5: write strobe only with chip select, output enable held off
  a_r5_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));
  // R5: write ends with both strobes rising on one edge
  a_r5_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n));
  // R6: drive starts only inside an active write
  a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drive) |-> !mem_we_n);
  // R2: busy right after a transfer
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          rd_capture,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= rd_capture;
      if (accept) begin
        mem_addr   <= cmd_addr;
        mem_dq_out <= cmd_wdata;
      end
      if (rd_capture) rsp_data <= mem_dq_in;
    end
  end

  // R4: response is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_ACC_PS  = 100000,
  parameter int T_OE_PS   = 50000,
  parameter int T_CYC_PS  = 100000,
  parameter int T_WP_PS   = 75000,
  parameter int T_DS_PS   = 40000,
  parameter int T_ODW_PS  = 35000,
  parameter int T_WR_PS   = 10000,
  parameter int T_DH_PS   = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int CYC_CYC = cyc_ceil(T_CYC_PS, CLK_PS);
  localparam int RD_CYC  = imax(imax(cyc_ceil(T_ACC_PS, CLK_PS),
                                     cyc_ceil(T_OE_PS, CLK_PS)),
                                imax(CYC_CYC - 1, 1));
  localparam int ODW_CYC = imax(cyc_ceil(T_ODW_PS, CLK_PS), 1);
  localparam int DS_CYC  = imax(cyc_ceil(T_DS_PS, CLK_PS), 1);
  localparam int WL_CYC  = imax(cyc_ceil(T_WP_PS, CLK_PS), ODW_CYC + DS_CYC);
  localparam int DRV_CYC = WL_CYC - ODW_CYC;
  localparam int REC_CYC = imax(imax(cyc_ceil(T_WR_PS, CLK_PS),
                                     cyc_ceil(T_DH_PS, CLK_PS)),
                                imax(CYC_CYC - WL_CYC, 1));
  localparam int MAX_CYC = imax(imax(RD_CYC, ODW_CYC), imax(DRV_CYC, REC_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          accept, tmr_load, tmr_done, rd_capture, dq_drive;
  logic [CW-1:0] tmr_init;

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .init (tmr_init),
    .done (tmr_done)
  );

  sram_seq_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .ODW_CYC(ODW_CYC),
    .DRV_CYC(DRV_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .tmr_done  (tmr_done),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_init  (tmr_init),
    .rd_capture(rd_capture),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .dq_drive  (dq_drive)
  );

  sram_seq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rd_capture(rd_capture),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign mem_dq_oe = dq_drive;

  // R8: address frozen while the memory is selected
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));
  // R2: no transfer edge while the sequencer is busy changes the address
  a_r2_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && mem_dq_oe) |=> $stable(mem_addr));

endmodule

// File: tb/sram_seq_test.sv
module sram_seq_test;

  localparam int CLK_PS = 8000;

  function automatic int cdiv(input int t, input int c);
    return (t + c - 1) / c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_CYC = cdiv(100000, CLK_PS);
  localparam int E_RD  = mx(mx(cdiv(100000, CLK_PS), cdiv(50000, CLK_PS)), E_CYC - 1);
  localparam int E_OD  = cdiv(35000, CLK_PS);
  localparam int E_DS  = cdiv(40000, CLK_PS);
  localparam int E_WL  = mx(cdiv(75000, CLK_PS), E_OD + E_DS);
  localparam int E_RC  = mx(mx(cdiv(10000, CLK_PS), cdiv(10000, CLK_PS)), mx(E_CYC - E_WL, 1));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [10:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_data, mem_dq_out, mem_dq_in;
  logic [10:0] mem_addr;

  always #4ns clk = ~clk;

  sram_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: data valid only once the access window has been met
  logic [7:0] mem_m [2048];
  logic [7:0] shadow [2048];
  int rd_cnt = 0, wr_cnt = 0, dd_cnt = 0, since_fall = 0;
  bit seen_fall = 0, prev_ce_low = 0, prev_wr = 0, prev_rsp = 0, mon_on = 0;
  logic [10:0] prev_addr = '0;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n && rd_cnt >= E_RD)
                     ? mem_m[mem_addr] : 8'hEE;

  always @(negedge clk) if (mon_on) begin
    if (!mem_oe_n && mem_dq_oe) chk(0, "R9 contention", 1, 0);
    if (!mem_we_n && (!mem_oe_n || mem_ce_n)) chk(0, "R5 strobe combo", 1, 0);
    if (!mem_ce_n && prev_ce_low && mem_addr != prev_addr)
      chk(0, "R8 addr moved", int'(mem_addr), int'(prev_addr));
    if (rsp_valid && prev_rsp) chk(0, "R4 pulse width", 2, 1);
    since_fall++;
    if (!mem_ce_n && !prev_ce_low) begin
      if (seen_fall) chk(since_fall >= E_CYC, "R10 cycle spacing", since_fall, E_CYC);
      seen_fall  = 1;
      since_fall = 0;
    end
    rd_cnt = (!mem_ce_n && !mem_oe_n) ? rd_cnt + 1 : 0;
    if (!mem_ce_n && !mem_we_n) begin
      wr_cnt++;
      if (mem_dq_oe) dd_cnt++;
      prev_wr = 1;
    end else if (prev_wr) begin
      chk(wr_cnt == E_WL, "R5 write width", wr_cnt, E_WL);
      chk(dd_cnt == E_WL - E_OD, "R6 drive window", dd_cnt, E_WL - E_OD);
      chk(dd_cnt >= E_DS, "R6 data setup", dd_cnt, E_DS);
      chk(mem_dq_oe, "R7 data hold", int'(mem_dq_oe), 1);
      if (mem_dq_oe) mem_m[mem_addr] = mem_dq_out;
      wr_cnt = 0; dd_cnt = 0; prev_wr = 0;
    end
    prev_ce_low = !mem_ce_n;
    prev_addr   = mem_addr;
    prev_rsp    = rsp_valid;
  end

  task automatic do_cmd(input bit wr, input int a, input int d);
    int n;
    cmd_valid = 1; cmd_write = wr; cmd_addr = 11'(a); cmd_wdata = 8'(d);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_addr = ~11'(a); cmd_wdata = ~8'(d);   // R2 scramble
    chk(!cmd_ready, "R2 busy", int'(cmd_ready), 0);
    n = 1;
    while (!cmd_ready && n < 40) begin @(negedge clk); n++; end
    if (wr) begin
      shadow[a] = 8'(d);
      chk(n == E_WL + E_RC + 1, "R7 ready return", n, E_WL + E_RC + 1);
    end else begin
      chk(n == E_RD + 1, "R3 read length", n, E_RD + 1);
      chk(rsp_valid, "R4 rsp_valid", int'(rsp_valid), 1);
      chk(rsp_data == shadow[a], "R4 read data", int'(rsp_data), int'(shadow[a]));
    end
  endtask

  function automatic int pat(input int a);
    return ((a * 37 + 11) ^ (a >> 8)) & 255;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset", 0, 1);
    chk(!mem_dq_oe && !rsp_valid, "R1 outputs in reset", int'(mem_dq_oe), 0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle", 0, 1);
    chk(cmd_ready && !mem_dq_oe && !rsp_valid, "R1 idle flags", int'(cmd_ready), 1);
    mon_on = 1;
    for (int a = 0; a < 2048; a++) do_cmd(1, a, pat(a));
    for (int a = 0; a < 2048; a++) do_cmd(0, a, 0);
    for (int a = 0; a < 256; a++) begin
      do_cmd(1, a * 8 + 3, ~pat(a) & 255);
      do_cmd(0, a * 8 + 3, 0);
    end
    do_cmd(1, 2047, 8'h00);
    do_cmd(1, 0, 8'hFF);
    do_cmd(0, 2047, 0);
    do_cmd(0, 0, 0);
    repeat (4) @(negedge clk);
    chk(mem_ce_n && !mem_dq_oe && cmd_ready, "R1 idle at end", int'(mem_ce_n), 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule